// File: doc/BRIEF.md
# Frame Self-Refresh Fetch Controller

This block decides, one video frame at a time, where a display DMA FIFO gets its pixels. It can fetch them from system memory over the interconnect, or it can replay data that is already held in the FIFO. Software controls it with one self-refresh enable bit and one priority bit. The FIFO reports when a full frame has been captured. The block drives three outputs: a fetch enable for the memory-request logic, a replay enable for the FIFO read side, and a priority level for the channel's interconnect requests.

Turning self-refresh on or off does not act at once. The change waits for a frame boundary. The block samples the enable in the cycle before each frame-start pulse. A frame that ends with the enable set is followed by a load frame. The load frame still fetches from memory while the FIFO fills. Once a load frame has filled the FIFO completely, every later frame is replayed from the FIFO and makes no memory accesses. If the enable is found low at a frame boundary, the next frame fetches from memory again.

Top module: `frame_replay_ctrl`

## Requirements
- R1: After reset, fetch_en is 1, replay_en is 0 and req_prio equals NORMAL_LVL (0 by default).
- R2: fetch_en and replay_en change only on the clock edge at which frame_start is 1. Between frame-start pulses they hold their values.
- R3: The enable value used at a frame boundary is the value sr_enable had in the cycle before the frame_start cycle.
- R4: A normal fetch frame that ends with the sampled enable at 1 is followed by a load frame. A load frame keeps fetch_en=1 and replay_en=0.
- R5: A load frame ends with the enable still 1. If fifo_full was 1 in any cycle of that frame, including its frame_start cycle, the following frames are replay frames with fetch_en=0 and replay_en=1.
- R6: A load frame that ends with the enable at 1 but saw no fifo_full pulse is followed by another load frame.
- R7: Any frame that ends with the sampled enable at 0 is followed by a normal fetch frame. This applies to normal, load and replay frames.
- R8: A fifo_full pulse in a normal fetch frame or a replay frame has no effect on later frames.
- R9: In every cycle, exactly one of fetch_en and replay_en is 1.
- R10: With PRIO_AT_FRAME=0, req_prio is HIGH_LVL (all ones by default) one cycle after prio_bit is 1, and NORMAL_LVL one cycle after prio_bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse that marks a frame boundary |
| sr_enable | input | 1 | Software self-refresh enable |
| prio_bit | input | 1 | Software priority select (1 = high) |
| fifo_full | input | 1 | FIFO reports that a whole frame is held |
| fetch_en | output | 1 | Frame data comes from memory |
| replay_en | output | 1 | Frame data comes from FIFO contents |
| req_prio | output | PRIO_W | Arbitration level for this channel's requests |

## Verification
The states that are hardest to tell apart are the normal fetch frame and the load frame. Both look the same at the ports. Only the frame that follows shows which one the block was in, and only when the right fifo_full timing is applied. The bench therefore covers every three-frame sequence of enable level and fifo_full pulse after a fresh reset, then observes a fourth frame. A reference state model in the bench predicts the outputs of each frame, so a stray fill pulse in a fetch frame or a replay frame shows up as a wrong transition later.

// File: rtl/frs_pkg.sv
package frs_pkg;
   typedef enum logic [1:0] {
      ST_FETCH  = 2'd0,
      ST_LOAD   = 2'd1,
      ST_REPLAY = 2'd2
   } frs_state_t;
endpackage

// File: rtl/frs_sampler.sv
module frs_sampler #(
   parameter int          PRIO_W        = 2,
   parameter logic [PRIO_W-1:0] NORMAL_LVL = '0,
   parameter logic [PRIO_W-1:0] HIGH_LVL   = '1,
   parameter bit          PRIO_AT_FRAME = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              sr_enable,
   input  logic              prio_bit,
   output logic              en_sampled,
   output logic [PRIO_W-1:0] prio_lvl
);
   always_ff @(posedge clk) begin
      if (!rst_n) en_sampled <= 1'b0;
      else        en_sampled <= sr_enable;
   end

   generate
      if (PRIO_AT_FRAME) begin : g_prio_frame
         always_ff @(posedge clk) begin
            if (!rst_n)           prio_lvl <= NORMAL_LVL;
            else if (frame_start) prio_lvl <= prio_bit ? HIGH_LVL : NORMAL_LVL;
         end
      end else begin : g_prio_cycle
         always_ff @(posedge clk) begin
            if (!rst_n) prio_lvl <= NORMAL_LVL;
            else        prio_lvl <= prio_bit ? HIGH_LVL : NORMAL_LVL;
         end
      end
   endgenerate
endmodule

// File: rtl/frs_load_tracker.sv
module frs_load_tracker (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_start,
   input  logic in_load,
   input  logic fifo_full,
   output logic frame_loaded
);
   logic seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n)           seen_q <= 1'b0;
      else if (frame_start) seen_q <= 1'b0;
      else if (in_load && fifo_full) seen_q <= 1'b1;
   end

   assign frame_loaded = in_load && (seen_q || fifo_full);
endmodule

// File: rtl/frs_fsm.sv
module frs_fsm
   import frs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic frame_start,
   input  logic en_sampled,
   input  logic frame_loaded,
   output logic in_load,
   output logic fetch_en,
   output logic replay_en
);
   frs_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (frame_start) begin
         unique case (state_q)
            ST_FETCH:  state_d = en_sampled ? ST_LOAD : ST_FETCH;
            ST_LOAD:   state_d = !en_sampled  ? ST_FETCH :
                                 frame_loaded ? ST_REPLAY : ST_LOAD;
            ST_REPLAY: state_d = en_sampled ? ST_REPLAY : ST_FETCH;
            default:   state_d = ST_FETCH;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_FETCH;
      else        state_q <= state_d;
   end

   assign in_load   = (state_q == ST_LOAD);
   assign replay_en = (state_q == ST_REPLAY);
   assign fetch_en  = !replay_en;
endmodule

// File: rtl/frame_replay_ctrl.sv
module frame_replay_ctrl #(
   parameter int          PRIO_W        = 2,
   parameter logic [PRIO_W-1:0] NORMAL_LVL = '0,
   parameter logic [PRIO_W-1:0] HIGH_LVL   = '1,
   parameter bit          PRIO_AT_FRAME = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              sr_enable,
   input  logic              prio_bit,
   input  logic              fifo_full,
   output logic              fetch_en,
   output logic              replay_en,
   output logic [PRIO_W-1:0] req_prio
);
   generate
      if (PRIO_W < 1) begin : g_bad_width
         $error("PRIO_W must be at least 1");
      end
      if (HIGH_LVL == NORMAL_LVL) begin : g_bad_levels
         $error("HIGH_LVL and NORMAL_LVL must differ");
      end
   endgenerate

   logic en_sampled;
   logic in_load;
   logic frame_loaded;

   frs_sampler #(
      .PRIO_W(PRIO_W), .NORMAL_LVL(NORMAL_LVL),
      .HIGH_LVL(HIGH_LVL), .PRIO_AT_FRAME(PRIO_AT_FRAME)
   ) u_sampler (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .sr_enable(sr_enable), .prio_bit(prio_bit),
      .en_sampled(en_sampled), .prio_lvl(req_prio)
   );

   frs_load_tracker u_tracker (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .in_load(in_load), .fifo_full(fifo_full), .frame_loaded(frame_loaded)
   );

   frs_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .en_sampled(en_sampled), .frame_loaded(frame_loaded),
      .in_load(in_load), .fetch_en(fetch_en), .replay_en(replay_en)
   );
endmodule

// File: rtl/frame_replay_ctrl_chk.sv
module frame_replay_ctrl_chk #(
   parameter int          PRIO_W        = 2,
   parameter logic [PRIO_W-1:0] NORMAL_LVL = '0,
   parameter logic [PRIO_W-1:0] HIGH_LVL   = '1,
   parameter bit          PRIO_AT_FRAME = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_start,
   input logic              sr_enable,
   input logic              prio_bit,
   input logic              in_load,
   input logic              fetch_en,
   input logic              replay_en,
   input logic [PRIO_W-1:0] req_prio
);
   AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({fetch_en, replay_en}) == 1); // R9

   AST_HOLD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && !frame_start) |=> ($stable(fetch_en) && $stable(replay_en))); // R2

   AST_REPLAY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(replay_en) |-> ($past(in_load) && $past(frame_start))); // R5

   AST_OFF_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && !$past(sr_enable)) |=> (fetch_en && !in_load)); // R7

   generate
      if (!PRIO_AT_FRAME) begin : g_prio_chk
         AST_PRIO_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (req_prio == ($past(prio_bit) ? HIGH_LVL : NORMAL_LVL))); // R10
      end
   endgenerate
endmodule

bind frame_replay_ctrl frame_replay_ctrl_chk #(
   .PRIO_W(PRIO_W), .NORMAL_LVL(NORMAL_LVL),
   .HIGH_LVL(HIGH_LVL), .PRIO_AT_FRAME(PRIO_AT_FRAME)
) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
   .sr_enable(sr_enable), .prio_bit(prio_bit), .in_load(in_load),
   .fetch_en(fetch_en), .replay_en(replay_en), .req_prio(req_prio)
);

// File: tb/sim_frame_replay_ctrl.sv
`timescale 1ns/1ps
module sim_frame_replay_ctrl;
   localparam int PW = 2;
   localparam int FLEN = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_start = 1'b0, sr_enable = 1'b0, prio_bit = 1'b0, fifo_full = 1'b0;
   logic fetch_en, replay_en;
   logic [PW-1:0] req_prio;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   int mst = 0; // 0 normal fetch, 1 load, 2 replay

   always #2.5 clk = ~clk;

   frame_replay_ctrl #(.PRIO_W(PW)) u0 (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .sr_enable(sr_enable), .prio_bit(prio_bit), .fifo_full(fifo_full),
      .fetch_en(fetch_en), .replay_en(replay_en), .req_prio(req_prio)
   );

   task automatic chk(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d (t=%0t)", tag, got, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; frame_start = 1'b0; sr_enable = 1'b0; fifo_full = 1'b0; prio_bit = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      mst = 0;
   endtask

   // One frame: enable held at en, optional fill pulse at cycle 2 (or on the
   // frame_start cycle when at_end), frame_start in the final cycle.
   task automatic run_frame(input bit en, input bit full, input bit at_end);
      bit filled = 1'b0;
      for (int i = 0; i < FLEN; i++) begin
         @(negedge clk);
         sr_enable   = en;
         frame_start = (i == FLEN - 1);
         fifo_full   = full && (at_end ? (i == FLEN - 1) : (i == 2));
         if (fifo_full && mst == 1) filled = 1'b1;
         // R2 R9: outputs follow the model state through the whole frame
         chk("R2/R9 fetch_en", int'(fetch_en), int'(mst != 2));
         chk("R2/R9 replay_en", int'(replay_en), int'(mst == 2));
      end
      case (mst)
         0: mst = en ? 1 : 0;                      // R4 R7 R8
         1: mst = !en ? 0 : (filled ? 2 : 1);      // R5 R6 R7
         default: mst = en ? 2 : 0;                // R7 R8
      endcase
      @(negedge clk);
      frame_start = 1'b0; fifo_full = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         fails++;
         $display("FAIL watchdog: got %0d cycles expected fewer than 100000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      do_reset();
      @(negedge clk);
      chk("R1 fetch_en", int'(fetch_en), 1);
      chk("R1 replay_en", int'(replay_en), 0);
      chk("R1 req_prio", int'(req_prio), 0);

      // R3 R4 R5 R6 R7 R8: every three-frame sequence of (enable, fill)
      for (int seq = 0; seq < 64; seq++) begin
         do_reset();
         for (int f = 0; f < 3; f++)
            run_frame(seq[2*f], seq[2*f+1], 1'b0);
         run_frame(seq[4], 1'b0, 1'b0);
      end

      // R5: fill reported in the frame_start cycle of the load frame
      do_reset();
      run_frame(1'b1, 1'b0, 1'b0);
      run_frame(1'b1, 1'b1, 1'b1);
      @(negedge clk);
      chk("R5 replay_en fill at boundary", int'(replay_en), 1);
      chk("R5 fetch_en fill at boundary", int'(fetch_en), 0);

      // R3: enable raised only in the frame_start cycle is not seen
      do_reset();
      for (int i = 0; i < FLEN; i++) begin
         @(negedge clk);
         frame_start = (i == FLEN - 1);
         sr_enable   = (i == FLEN - 1);
      end
      @(negedge clk);
      frame_start = 1'b0; sr_enable = 1'b0; fifo_full = 1'b1;
      @(negedge clk);
      fifo_full = 1'b0;
      for (int i = 0; i < FLEN; i++) begin
         @(negedge clk);
         sr_enable = 1'b1;
         frame_start = (i == FLEN - 1);
      end
      @(negedge clk);
      frame_start = 1'b0;
      @(negedge clk);
      chk("R3 late enable ignored (no replay)", int'(replay_en), 0);

      // R10: priority level follows prio_bit one cycle later
      do_reset();
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         prio_bit = k[0] ^ k[2];
         @(negedge clk);
         chk("R10 req_prio", int'(req_prio), (k[0] ^ k[2]) ? 3 : 0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule